// File: doc/BRIEF.md
# Backplane Bus Slave with Register Window

This block is a clocked model of a slave on an asynchronous parallel backplane. It owns a local window of 32-bit words. A master selects the window with an address and a 6-bit address modifier, then moves data one beat at a time. Each beat uses a data-strobe / acknowledge handshake. All bus signals are active low and arrive already synchronised to `clk`.

Byte address bit 0 has no line of its own; it is recovered from the two data strobes. Transfer size comes from those strobes together with a longword line. Bytes are laid out big-endian: offset 0 is the most significant byte of a word.

Block transfers keep the address lines still. The slave steps an internal counter after each acknowledged beat and refuses beats once the counter has crossed a 256-byte edge. Requests the slave cannot serve are answered with the bus-error line instead of the acknowledge.

Top module: `bkpl_slave`

## Requirements
- R1: A cycle is served only when `adr[31:WIN_BITS]` equals `BASE[31:WIN_BITS]` and `amod` is 0x09 (single cycle) or 0x0B (32-bit block). For any other address or modifier, `dtack_n` and `berr_n` stay high for the whole cycle and the memory is left unchanged.
- R2: Size and lane encoding:
  - Both strobes low with `lword_n` low is 4 bytes on `dat[31:0]`.
  - Both strobes low with `lword_n` high is 2 bytes on `dat[15:0]`. Byte offset `adr[1]*2` sits on `dat[15:8]`.
  - Only `ds1_n` low is 1 byte at an even offset; only `ds0_n` low is 1 byte at an odd offset. The byte travels on `dat[7:0]`.
  - Unused read lanes are zero.
- R3: Byte order is big-endian. After a 32-bit write of 0x11223344 at offset 0, a 1-byte read at offset 0 gives 0x11, at offset 3 gives 0x44, and a 2-byte read at offset 2 gives 0x3344.
- R4: Handshake timing:
  - The response (`dtack_n` or `berr_n` low, read data on `dat_o`) appears on the clock after a strobe is sampled low.
  - The response is held while any strobe stays low.
  - It is released on the clock after both strobes are sampled high.
  - Outside a response, `dat_o` is zero.
- R5: A 4-byte access whose offset has bit 1 set gets `berr_n` instead of `dtack_n`, and a write of that kind changes no memory.
- R6: In a block cycle, the internal offset starts at the latched address and advances by 4 after every acknowledged beat, while the address lines stay unchanged.
- R7: In a block cycle, once the counter has advanced past a 256-byte edge (the beat at offset 0xFC modulo 256 was acknowledged), every further beat of that cycle gets `berr_n` and writes nothing.
- R8: A block-cycle beat that is not 4 bytes gets `berr_n` and writes nothing.
- R9: `dtack_n` and `berr_n` are never low in the same cycle.
- R10: After reset, `dtack_n` and `berr_n` are high and `dat_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| as_n | input | 1 | Address strobe, active low |
| adr | input | 31 | Address bits 31..1 |
| amod | input | 6 | Address modifier |
| ds0_n | input | 1 | Data strobe for the odd byte, active low |
| ds1_n | input | 1 | Data strobe for the even byte, active low |
| lword_n | input | 1 | Longword select, active low |
| write_n | input | 1 | Low for write, high for read |
| dat_i | input | 32 | Write data from the master |
| dat_o | output | 32 | Read data to the master |
| dtack_n | output | 1 | Data acknowledge, active low |
| berr_n | output | 1 | Bus error, active low |

## Verification
Every word of the window is written with 32-bit single cycles and read back. Selected words are then read and written at every 1-byte and 2-byte offset, so a lane swap or a wrong strobe-to-offset mapping shows up as a byte mismatch.

All 62 foreign modifier codes, and addresses just outside the window, are driven as writes. They must draw no response and must leave the target word intact, which separates decoding of the address from decoding of the modifier.

Block cycles are run:
- well inside a 256-byte page, to show that the counter steps correctly;
- up to a page edge, to show that the fifth beat faults while the four before it land;
- with a 2-byte beat, to show the size fault.

Misaligned 4-byte accesses complete the error cases.

// File: rtl/bkpl_slave.sv
module bkpl_slave #(
  parameter logic [31:0] BASE     = 32'h00A0_0000,
  parameter int          WIN_BITS = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        as_n,
  input  logic [31:1] adr,
  input  logic [5:0]  amod,
  input  logic        ds0_n,
  input  logic        ds1_n,
  input  logic        lword_n,
  input  logic        write_n,
  input  logic [31:0] dat_i,
  output logic [31:0] dat_o,
  output logic        dtack_n,
  output logic        berr_n
);
  localparam int WORDS = 1 << (WIN_BITS - 2);
  localparam int EDGE_BITS = 8;
  localparam logic [5:0] AM_SGL = 6'h09;
  localparam logic [5:0] AM_BLK = 6'h0B;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RESP, S_SKIP} st_t;
  st_t st;

  logic [WIN_BITS-1:0] ofs;
  logic blk, crossed;
  logic [31:0] mem [WORDS];

  wire strobe = !ds0_n || !ds1_n;
  wire both   = !ds0_n && !ds1_n;
  wire a0     = both ? 1'b0 : ds1_n;
  wire [1:0] bofs = {ofs[1], a0};
  wire [WIN_BITS-3:0] widx = ofs[WIN_BITS-1:2];
  wire sz4 = both && !lword_n;
  wire sz2 = both && lword_n;
  wire hit = (adr[31:WIN_BITS] == BASE[31:WIN_BITS]) && (amod == AM_SGL || amod == AM_BLK);
  wire fault = (sz4 && ofs[1]) || (blk && (!sz4 || crossed));
  wire beat = (st == S_WAIT) && !as_n && strobe;
  wire edge_next = &ofs[EDGE_BITS-1:2];

  logic [31:0] word, rd, wdat;
  logic [3:0] bm;

  assign word = mem[widx];

  always_comb begin
    if (sz4) begin
      rd = word;
      wdat = dat_i;
      bm = 4'b1111;
    end else if (sz2) begin
      rd = {16'h0, ofs[1] ? word[15:0] : word[31:16]};
      wdat = {2{dat_i[15:0]}};
      bm = ofs[1] ? 4'b1100 : 4'b0011;
    end else begin
      case (bofs)
        2'd0: rd = {24'h0, word[31:24]};
        2'd1: rd = {24'h0, word[23:16]};
        2'd2: rd = {24'h0, word[15:8]};
        default: rd = {24'h0, word[7:0]};
      endcase
      wdat = {4{dat_i[7:0]}};
      bm = 4'b0001 << bofs;
    end
  end

  always_ff @(posedge clk) begin
    if (beat && !fault && !write_n)
      for (int j = 0; j < 4; j++)
        if (bm[j]) mem[widx][31-8*j -: 8] <= wdat[31-8*j -: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ofs <= '0;
      blk <= 1'b0;
      crossed <= 1'b0;
      dtack_n <= 1'b1;
      berr_n <= 1'b1;
      dat_o <= '0;
    end else begin
      case (st)
        S_IDLE: if (!as_n) begin
          ofs <= {adr[WIN_BITS-1:1], 1'b0};
          blk <= (amod == AM_BLK);
          crossed <= 1'b0;
          st <= hit ? S_WAIT : S_SKIP;
        end
        S_WAIT: if (as_n) st <= S_IDLE;
          else if (strobe) begin
            st <= S_RESP;
            if (fault) berr_n <= 1'b0;
            else begin
              dtack_n <= 1'b0;
              dat_o <= write_n ? rd : 32'h0;
              if (blk) begin
                ofs <= ofs + WIN_BITS'(4);
                if (edge_next) crossed <= 1'b1;
              end
            end
          end
        S_RESP: if (!strobe) begin
          dtack_n <= 1'b1;
          berr_n <= 1'b1;
          dat_o <= '0;
          st <= as_n ? S_IDLE : S_WAIT;
        end
        default: if (as_n) st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bkpl_slave_chk.sv
module bkpl_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] amod,
  input logic       ds0_n,
  input logic       ds1_n,
  input logic       dtack_n,
  input logic       berr_n
);
  assert_ack_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dtack_n && !berr_n));
  assert_ack_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dtack_n && (!ds0_n || !ds1_n)) |=> !dtack_n);
  assert_err_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!berr_n && (!ds0_n || !ds1_n)) |=> !berr_n);
  assert_release_after_ds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dtack_n) || $rose(berr_n)) |-> $past(ds0_n && ds1_n));
  assert_resp_after_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dtack_n) || $fell(berr_n)) |-> $past(!ds0_n || !ds1_n));
  assert_ack_modifier_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_n) |-> $past(amod == 6'h09 || amod == 6'h0B));
endmodule

bind bkpl_slave bkpl_slave_chk u_chk (.*);

// File: tb/sim_bkpl_slave.sv
`timescale 1ns/1ps
module sim_bkpl_slave;
  localparam logic [31:0] BASE = 32'h00A0_0000;
  localparam int NB = 1024;

  logic clk = 0, rst_n = 0, as_n = 1, ds0_n = 1, ds1_n = 1, lword_n = 1, write_n = 1;
  logic [31:1] adr = '0;
  logic [5:0] amod = '0;
  logic [31:0] dat_i = '0, dat_o;
  logic dtack_n, berr_n;
  logic [7:0] refm [NB];
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  bkpl_slave u0 (.clk, .rst_n, .as_n, .adr, .amod, .ds0_n, .ds1_n, .lword_n,
                 .write_n, .dat_i, .dat_o, .dtack_n, .berr_n);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input int nb, input int a);
    if (nb == 4) return {refm[a], refm[a+1], refm[a+2], refm[a+3]};
    if (nb == 2) return {16'h0, refm[a], refm[a+1]};
    return {24'h0, refm[a]};
  endfunction

  task automatic put_ref(input int nb, input int a, input logic [31:0] wd);
    if (nb == 4) {refm[a], refm[a+1], refm[a+2], refm[a+3]} = wd;
    else if (nb == 2) {refm[a], refm[a+1]} = wd[15:0];
    else refm[a] = wd[7:0];
  endtask

  task automatic start(input logic [31:0] a, input logic [5:0] am);
    @(negedge clk);
    adr = a[31:1];
    amod = am;
    as_n = 0;
  endtask

  task automatic stop();
    @(negedge clk);
    as_n = 1;
    @(negedge clk);
  endtask

  // resp: 0 none, 1 ack, 2 error, 3 both
  task automatic beat(input int nb, input bit a0, input bit wr, input logic [31:0] wd,
                      output int resp, output logic [31:0] rd);
    @(negedge clk);
    write_n = !wr;
    dat_i = wd;
    lword_n = (nb != 4);
    if (nb == 1) begin ds1_n = a0; ds0_n = !a0; end
    else begin ds1_n = 0; ds0_n = 0; end
    @(negedge clk);
    resp = (!dtack_n ? 1 : 0) + (!berr_n ? 2 : 0);
    rd = dat_o;
    check("R9 exclusive", {31'h0, (resp == 3)}, 32'h0);
    @(negedge clk);
    check("R4 held", {30'h0, !berr_n, !dtack_n}, resp[1:0]);
    ds0_n = 1; ds1_n = 1;
    @(negedge clk);
    check("R4 released", {30'h0, !berr_n, !dtack_n, dat_o}, 32'h0);
  endtask

  task automatic single(input logic [31:0] a, input logic [5:0] am, input int nb, input bit wr,
                        input logic [31:0] wd, input int exp_resp, input string req);
    int resp;
    logic [31:0] rd;
    int o = int'(a[9:0]);
    start(a, am);
    beat(nb, a[0], wr, wd, resp, rd);
    stop();
    check(req, resp, exp_resp);
    if (exp_resp == 1 && !wr) check(req, rd, exp_rd(nb, o));
    if (exp_resp == 1 && wr) put_ref(nb, o, wd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int resp;
    logic [31:0] rd;
    for (int i = 0; i < NB; i++) refm[i] = 8'h0;
    repeat (3) @(negedge clk);
    check("R10 reset", {dat_o[29:0], dtack_n, berr_n}, 32'h3);
    rst_n = 1;

    // R2 fill: 32-bit single cycles over the whole window, then read back
    for (int i = 0; i < NB/4; i++)
      single(BASE + 4*i, 6'h09, 4, 1, i * 32'h9E37_79B1 + 32'h1122_3344, 1, "R2 d32 write");
    for (int i = 0; i < NB/4; i++)
      single(BASE + 4*i, 6'h09, 4, 0, 0, 1, "R2 d32 read");

    // R3: big-endian example
    single(BASE, 6'h09, 4, 1, 32'h1122_3344, 1, "R3 write");
    single(BASE, 6'h09, 1, 0, 0, 1, "R3 byte0");
    check("R3 byte0 value", {24'h0, refm[0]}, 32'h11);
    single(BASE + 3, 6'h09, 1, 0, 0, 1, "R3 byte3");
    check("R3 byte3 value", {24'h0, refm[3]}, 32'h44);
    single(BASE + 2, 6'h09, 2, 0, 0, 1, "R3 half2");

    // R2: narrow reads and writes on every offset of some words
    for (int a = 0; a < 64; a++) single(BASE + a, 6'h09, 1, 0, 0, 1, "R2 d8 read");
    for (int a = 0; a < 64; a += 2) single(BASE + a, 6'h09, 2, 0, 0, 1, "R2 d16 read");
    for (int a = 64; a < 96; a++) single(BASE + a, 6'h09, 1, 1, 32'hFFFF_FF00 | a, 1, "R2 d8 write");
    for (int a = 96; a < 128; a += 2) single(BASE + a, 6'h09, 2, 1, 32'hABCD_0000 | (a * 257), 1, "R2 d16 write");
    for (int a = 64; a < 128; a += 4) single(BASE + a, 6'h09, 4, 0, 0, 1, "R2 narrow readback");

    // R5: misaligned 32-bit
    single(BASE + 32'h22, 6'h09, 4, 1, 32'hDEAD_BEEF, 2, "R5 misaligned write");
    single(BASE + 32'h20, 6'h09, 4, 0, 0, 1, "R5 word unchanged");
    single(BASE + 32'h06, 6'h09, 4, 0, 0, 2, "R5 misaligned read");

    // R1: foreign modifiers and addresses
    for (int m = 0; m < 64; m++)
      if (m != 9 && m != 11) single(BASE + 32'h10, 6'(m), 4, 1, 32'h0BAD_0000 | m, 0, "R1 modifier");
    single(BASE + 32'h400, 6'h09, 4, 1, 32'h0BAD_F00D, 0, "R1 above window");
    single(BASE - 4, 6'h0B, 4, 1, 32'h0BAD_F00D, 0, "R1 below window");
    single(32'h0000_0010, 6'h09, 4, 1, 32'h0BAD_F00D, 0, "R1 other base");
    single(BASE + 32'h10, 6'h09, 4, 0, 0, 1, "R1 word unchanged");

    // R6/R7: block write up to a 256-byte edge
    start(BASE + 32'h1F0, 6'h0B);
    for (int k = 0; k < 5; k++) begin
      beat(4, 0, 1, 32'hB10C_0000 + k, resp, rd);
      check(k < 4 ? "R6 block write ack" : "R7 edge error", resp, k < 4 ? 1 : 2);
      if (k < 4) put_ref(4, 32'h1F0 + 4*k, 32'hB10C_0000 + k);
    end
    stop();
    for (int k = 0; k < 5; k++) single(BASE + 32'h1F0 + 4*k, 6'h09, 4, 0, 0, 1, "R6 R7 block readback");

    // R6: block read inside a page
    start(BASE + 32'h100, 6'h0B);
    for (int k = 0; k < 8; k++) begin
      beat(4, 0, 0, 0, resp, rd);
      check("R6 block read ack", resp, 1);
      check("R6 block read data", rd, exp_rd(4, 32'h100 + 4*k));
    end
    stop();

    // R8: narrow beat in block cycle
    start(BASE + 32'h40, 6'h0B);
    beat(2, 0, 1, 32'h0000_5A5A, resp, rd);
    check("R8 narrow block beat", resp, 2);
    stop();
    single(BASE + 32'h40, 6'h09, 4, 0, 0, 1, "R8 word unchanged");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule